// File: doc/BRIEF.md
# Instruction Cache Parity Recovery Controller

This block is the lookup and error-recovery engine of a small two-way set-associative instruction cache. It holds its own tag and line arrays. Every stored tag carries one even-parity bit, and every 20-bit slice of a stored line carries one even-parity bit. These bits are produced when a line is filled from the next memory level. A fetch is accepted on a valid/ready handshake. One cycle later the addressed set is read, its parity is checked and the hit is resolved.

A clean hit answers in the following cycle. A miss or a parity failure sends a single-cycle refill request to the next level and holds the fetch until the refill data returns. A parity failure also clears both ways of the set, so a corrupted line is never served. The fault is then reported on a one-cycle event output that says whether it lay in a tag, in data, or in both. Parity detects only odd numbers of flipped bits in a slice. An even number of flips in one slice is deliberately left undetected. A fault-injection port XORs a mask into a stored tag or line, which emulates array upsets.

Top module: `icache_par_recover`

## Requirements
- R1: After reset every way of every set is invalid. `req_ready_o` is 1 and all other outputs are 0. The first fetch to any address misses.
- R2: When a fetch matches the tag of a valid way and no parity fault is found, `rsp_valid_o` is 1 for one cycle, two cycles after acceptance, carrying that way's line. No refill request is issued.
- R3: On a miss, `fill_req_valid_o` pulses for exactly one cycle, two cycles after acceptance, with `fill_req_addr_o` equal to the fetch address. The response carries `fill_rsp_data_i` and appears in the cycle after `fill_rsp_valid_i`. `req_ready_o` stays 0 from acceptance until the response. A refill return only ever arrives while a request is outstanding.
- R4: Parity is even. There is one bit over the 31-bit tag and one bit over each 20-bit slice of the 40-bit line. All of these bits are generated at fill. A single flipped bit in any valid tag, or in any slice of the matching way's line, is detected on the next lookup of that set.
- R5: On a detected fault, both ways of the set are invalidated and the fetch is handled as a miss. This applies even when the fault lies in the way that did not match. A later fetch to the other way's line therefore also misses.
- R6: On a detected fault, `err_valid_o` pulses for one cycle, in the same cycle as the refill request. `err_src_o` bit 1 flags a tag fault in any valid way, and bit 0 flags a data fault in the matching way. Both bits may be set together.
- R7: Two flipped bits in the same 20-bit slice are not detected. The fetch hits, returns the corrupted line and raises no error.
- R8: A refill goes into the lowest-numbered invalid way of the set. When no way is invalid, it goes into the way named by a per-set pointer. The pointer starts at 0 and advances by one, modulo the way count, on every refill into that set.
- R9: An injection cycle XORs `inj_mask_i` into the tag (low 31 bits, when `inj_tag_i`=1) or into the line (when `inj_tag_i`=0) of the chosen set and way, leaving the stored parity as it is. A refill write to the same entry in the same cycle takes precedence over the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Fetch request valid |
| req_addr_i | input | ADDR_W (33) | Line address: low INDEX_W bits select the set, the rest form the tag |
| req_ready_o | output | 1 | Controller idle and able to accept a fetch |
| rsp_valid_o | output | 1 | One-cycle fetch response strobe |
| rsp_data_o | output | LINE_W (40) | Returned line |
| fill_req_valid_o | output | 1 | One-cycle refill request to the next level |
| fill_req_addr_o | output | ADDR_W (33) | Line address being refilled |
| fill_rsp_valid_i | input | 1 | Refill data return |
| fill_rsp_data_i | input | LINE_W (40) | Refill line |
| err_valid_o | output | 1 | One-cycle parity fault event |
| err_src_o | output | 2 | Bit 1 tag fault, bit 0 data fault |
| inj_valid_i | input | 1 | Fault injection strobe |
| inj_set_i | input | INDEX_W (2) | Injection set |
| inj_way_i | input | 1 | Injection way |
| inj_tag_i | input | 1 | 1 to corrupt the tag, 0 to corrupt the line |
| inj_mask_i | input | LINE_W (40) | XOR mask |

## Verification
Two functions can collide in one cycle. A refill can write an entry in the same edge that injection corrupts it, and a tag fault in one way can coincide with a data fault in the matching way during a single lookup. The bench provokes the first by driving the injection strobe into the refill's target way in the very cycle the refill data returns. It then judges the result by the next fetch to that line, which must hit cleanly with no error event. The second case is provoked by corrupting the matching way's line and the other way's tag before one fetch. That fetch must report both source bits, and every line of the set must be gone afterwards.

// File: rtl/icpr_pkg.sv
package icpr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_REQ, ST_WAIT} icpr_state_e;
  typedef struct packed {
    logic tag;
    logic data;
  } icpr_err_t;
endpackage

// File: rtl/icpr_parity.sv
module icpr_parity #(
  parameter int W = 40,
  parameter int G = 20,
  localparam int NG = W / G
) (
  input  logic [W-1:0]  data_i,
  output logic [NG-1:0] par_o
);
  for (genvar g = 0; g < NG; g++) begin : g_gran
    assign par_o[g] = ^data_i[g*G +: G];
  end
endmodule

// File: rtl/icpr_array.sv
module icpr_array #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 31,
  parameter int LINE_W = 40,
  parameter int GRAN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NG    = LINE_W / GRAN_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [IDX_W-1:0]                  rd_set_i,
  output logic [WAYS-1:0]                   rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag_o,
  output logic [WAYS-1:0]                   rd_tpar_o,
  output logic [WAYS-1:0][LINE_W-1:0]       rd_data_o,
  output logic [WAYS-1:0][NG-1:0]           rd_dpar_o,
  output logic [WAY_W-1:0]                  rd_ptr_o,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_set_i,
  input  logic [WAY_W-1:0]                  wr_way_i,
  input  logic [TAG_W-1:0]                  wr_tag_i,
  input  logic [LINE_W-1:0]                 wr_data_i,
  input  logic                              inv_en_i,
  input  logic [IDX_W-1:0]                  inv_set_i,
  input  logic                              inj_en_i,
  input  logic [IDX_W-1:0]                  inj_set_i,
  input  logic [WAY_W-1:0]                  inj_way_i,
  input  logic                              inj_tag_i,
  input  logic [LINE_W-1:0]                 inj_mask_i
);
  logic [SETS-1:0][WAYS-1:0]              all_valid;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   all_tag;
  logic [SETS-1:0][WAYS-1:0]              all_tpar;
  logic [SETS-1:0][WAYS-1:0][LINE_W-1:0]  all_data;
  logic [SETS-1:0][WAYS-1:0][NG-1:0]      all_dpar;
  logic [SETS-1:0][WAY_W-1:0]             all_ptr;
  logic                                   wr_tpar;
  logic [NG-1:0]                          wr_dpar;

  icpr_parity #(.W(TAG_W),  .G(TAG_W))  u_wr_tpar (.data_i(wr_tag_i),  .par_o(wr_tpar));
  icpr_parity #(.W(LINE_W), .G(GRAN_W)) u_wr_dpar (.data_i(wr_data_i), .par_o(wr_dpar));

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAY_W-1:0] ptr_q;
    logic             set_wr;
    assign set_wr = wr_en_i && (wr_set_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q <= '0;
      else if (set_wr) ptr_q <= (ptr_q == WAY_W'(WAYS - 1)) ? '0 : ptr_q + WAY_W'(1);
    end
    assign all_ptr[s] = ptr_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic              valid_q;
      logic [TAG_W-1:0]  tag_q;
      logic              tpar_q;
      logic [LINE_W-1:0] data_q;
      logic [NG-1:0]     dpar_q;
      logic              hit_wr, hit_inj;

      assign hit_wr  = set_wr && (wr_way_i == WAY_W'(w));
      assign hit_inj = inj_en_i && (inj_set_i == IDX_W'(s)) && (inj_way_i == WAY_W'(w));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   valid_q <= 1'b0;
        else if (hit_wr)                               valid_q <= 1'b1;
        else if (inv_en_i && inv_set_i == IDX_W'(s))   valid_q <= 1'b0;
      end

      // refill write wins over a same-cycle injection
      always_ff @(posedge clk_i) begin
        if (hit_wr) begin
          tag_q  <= wr_tag_i;
          tpar_q <= wr_tpar;
          data_q <= wr_data_i;
          dpar_q <= wr_dpar;
        end else if (hit_inj) begin
          if (inj_tag_i) tag_q  <= tag_q ^ inj_mask_i[TAG_W-1:0];
          else           data_q <= data_q ^ inj_mask_i;
        end
      end

      assign all_valid[s][w] = valid_q;
      assign all_tag[s][w]   = tag_q;
      assign all_tpar[s][w]  = tpar_q;
      assign all_data[s][w]  = data_q;
      assign all_dpar[s][w]  = dpar_q;
    end
  end

  assign rd_valid_o = all_valid[rd_set_i];
  assign rd_tag_o   = all_tag[rd_set_i];
  assign rd_tpar_o  = all_tpar[rd_set_i];
  assign rd_data_o  = all_data[rd_set_i];
  assign rd_dpar_o  = all_dpar[rd_set_i];
  assign rd_ptr_o   = all_ptr[rd_set_i];

  assert_set_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i |=> (all_valid[$past(inv_set_i)] == '0));

  assert_fill_sets_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> all_valid[$past(wr_set_i)][$past(wr_way_i)]);
endmodule

// File: rtl/icpr_ctrl.sv
module icpr_ctrl import icpr_pkg::*; #(
  parameter int ADDR_W = 33,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int LINE_W = 40,
  parameter int GRAN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int NG    = LINE_W / GRAN_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic                        req_ready_o,
  output logic                        rsp_valid_o,
  output logic [LINE_W-1:0]           rsp_data_o,
  output logic                        fill_req_valid_o,
  output logic [ADDR_W-1:0]           fill_req_addr_o,
  input  logic                        fill_rsp_valid_i,
  input  logic [LINE_W-1:0]           fill_rsp_data_i,
  output logic                        err_valid_o,
  output logic [1:0]                  err_src_o,
  output logic [IDX_W-1:0]            rd_set_o,
  input  logic [WAYS-1:0]             rd_valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag_i,
  input  logic [WAYS-1:0]             rd_tpar_i,
  input  logic [WAYS-1:0][LINE_W-1:0] rd_data_i,
  input  logic [WAYS-1:0][NG-1:0]     rd_dpar_i,
  input  logic [WAY_W-1:0]            rd_ptr_i,
  output logic                        wr_en_o,
  output logic [IDX_W-1:0]            wr_set_o,
  output logic [WAY_W-1:0]            wr_way_o,
  output logic [TAG_W-1:0]            wr_tag_o,
  output logic [LINE_W-1:0]           wr_data_o,
  output logic                        inv_en_o,
  output logic [IDX_W-1:0]            inv_set_o
);
  icpr_state_e         state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [TAG_W-1:0]    cur_tag;
  logic [WAYS-1:0]     tcalc, tag_bad, match;
  logic [WAYS-1:0][NG-1:0] dcalc;
  logic [WAY_W-1:0]    hit_way, victim;
  logic                hit, data_bad, tag_err, any_err;
  logic                rsp_valid_q, fill_req_q, err_valid_q;
  logic [LINE_W-1:0]   rsp_data_q;
  icpr_err_t           err_src_q;

  assign rd_set_o = addr_q[IDX_W-1:0];
  assign cur_tag  = addr_q[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_chk
    icpr_parity #(.W(TAG_W),  .G(TAG_W))  u_tchk (.data_i(rd_tag_i[w]),  .par_o(tcalc[w]));
    icpr_parity #(.W(LINE_W), .G(GRAN_W)) u_dchk (.data_i(rd_data_i[w]), .par_o(dcalc[w]));
    assign tag_bad[w] = rd_valid_i[w] && (tcalc[w] != rd_tpar_i[w]);
    assign match[w]   = rd_valid_i[w] && (rd_tag_i[w] == cur_tag);
  end

  always_comb begin
    hit_way = '0;
    victim  = rd_ptr_i;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])       hit_way = WAY_W'(w);
      if (!rd_valid_i[w]) victim  = WAY_W'(w);
    end
  end

  assign hit      = |match;
  assign data_bad = hit && (dcalc[hit_way] != rd_dpar_i[hit_way]);
  assign tag_err  = |tag_bad;
  assign any_err  = tag_err || data_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      fill_req_q  <= 1'b0;
      err_valid_q <= 1'b0;
      err_src_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      fill_req_q  <= 1'b0;
      err_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit && !any_err) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= rd_data_i[hit_way];
            state_q     <= ST_IDLE;
          end else begin
            fill_req_q  <= 1'b1;
            err_valid_q <= any_err;
            err_src_q   <= '{tag: tag_err, data: data_bad};
            state_q     <= ST_REQ;
          end
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (fill_rsp_valid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= fill_rsp_data_i;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_data_o       = rsp_data_q;
  assign fill_req_valid_o = fill_req_q;
  assign fill_req_addr_o  = addr_q;
  assign err_valid_o      = err_valid_q;
  assign err_src_o        = err_src_q;

  assign inv_en_o  = (state_q == ST_LOOK) && any_err;
  assign inv_set_o = rd_set_o;
  assign wr_en_o   = (state_q == ST_WAIT) && fill_rsp_valid_i;
  assign wr_set_o  = rd_set_o;
  assign wr_way_o  = victim;
  assign wr_tag_o  = cur_tag;
  assign wr_data_o = fill_rsp_data_i;

  assert_fill_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_rsp_valid_i |-> (state_q == ST_WAIT));

  assert_fill_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |=> !fill_req_valid_o);

  assert_busy_until_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |-> !req_ready_o);

  assert_err_with_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (fill_req_valid_o && err_src_o != 2'b00));

  assert_rsp_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (req_ready_o && !fill_req_valid_o));

  assert_no_rsp_after_fill_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/icache_par_recover.sv
module icache_par_recover #(
  parameter int ADDR_W  = 33,
  parameter int INDEX_W = 2,
  parameter int WAYS    = 2,
  parameter int LINE_W  = 40,
  parameter int GRAN_W  = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      req_ready_o,
  output logic                      rsp_valid_o,
  output logic [LINE_W-1:0]         rsp_data_o,
  output logic                      fill_req_valid_o,
  output logic [ADDR_W-1:0]         fill_req_addr_o,
  input  logic                      fill_rsp_valid_i,
  input  logic [LINE_W-1:0]         fill_rsp_data_i,
  output logic                      err_valid_o,
  output logic [1:0]                err_src_o,
  input  logic                      inj_valid_i,
  input  logic [INDEX_W-1:0]        inj_set_i,
  input  logic [$clog2(WAYS)-1:0]   inj_way_i,
  input  logic                      inj_tag_i,
  input  logic [LINE_W-1:0]         inj_mask_i
);
  localparam int SETS  = 2 ** INDEX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int NG    = LINE_W / GRAN_W;

  logic [INDEX_W-1:0]            rd_set, wr_set, inv_set;
  logic [WAYS-1:0]               rd_valid, rd_tpar;
  logic [WAYS-1:0][TAG_W-1:0]    rd_tag;
  logic [WAYS-1:0][LINE_W-1:0]   rd_data;
  logic [WAYS-1:0][NG-1:0]       rd_dpar;
  logic [WAY_W-1:0]              rd_ptr, wr_way;
  logic                          wr_en, inv_en;
  logic [TAG_W-1:0]              wr_tag;
  logic [LINE_W-1:0]             wr_data;

  icpr_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .GRAN_W(GRAN_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .rsp_valid_o, .rsp_data_o, .fill_req_valid_o, .fill_req_addr_o,
    .fill_rsp_valid_i, .fill_rsp_data_i, .err_valid_o, .err_src_o,
    .rd_set_o(rd_set), .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_tpar_i(rd_tpar),
    .rd_data_i(rd_data), .rd_dpar_i(rd_dpar), .rd_ptr_i(rd_ptr),
    .wr_en_o(wr_en), .wr_set_o(wr_set), .wr_way_o(wr_way), .wr_tag_o(wr_tag),
    .wr_data_o(wr_data), .inv_en_o(inv_en), .inv_set_o(inv_set)
  );

  icpr_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W), .GRAN_W(GRAN_W)
  ) u_array (
    .clk_i, .rst_ni,
    .rd_set_i(rd_set), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_tpar_o(rd_tpar),
    .rd_data_o(rd_data), .rd_dpar_o(rd_dpar), .rd_ptr_o(rd_ptr),
    .wr_en_i(wr_en), .wr_set_i(wr_set), .wr_way_i(wr_way), .wr_tag_i(wr_tag),
    .wr_data_i(wr_data), .inv_en_i(inv_en), .inv_set_i(inv_set),
    .inj_en_i(inj_valid_i), .inj_set_i(inj_set_i), .inj_way_i(inj_way_i),
    .inj_tag_i(inj_tag_i), .inj_mask_i(inj_mask_i)
  );
endmodule

// File: tb/icache_par_recover_bench.sv
`timescale 1ns/1ps
module icache_par_recover_bench;
  localparam int ADDR_W = 33, INDEX_W = 2, WAYS = 2, LINE_W = 40, GRAN_W = 20;
  localparam int SETS = 4, TAG_W = 31, NG = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, fill_rsp_valid = 0, inj_valid = 0, inj_tag = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LINE_W-1:0] fill_rsp_data = '0, inj_mask = '0;
  logic [INDEX_W-1:0] inj_set = '0;
  logic inj_way = 1'b0;
  logic req_ready, rsp_valid, fill_req_valid, err_valid;
  logic [LINE_W-1:0] rsp_data;
  logic [ADDR_W-1:0] fill_req_addr;
  logic [1:0] err_src;

  icache_par_recover u_icache_par_recover (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .fill_req_valid_o(fill_req_valid), .fill_req_addr_o(fill_req_addr),
    .fill_rsp_valid_i(fill_rsp_valid), .fill_rsp_data_i(fill_rsp_data),
    .err_valid_o(err_valid), .err_src_o(err_src), .inj_valid_i(inj_valid),
    .inj_set_i(inj_set), .inj_way_i(inj_way), .inj_tag_i(inj_tag), .inj_mask_i(inj_mask)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural reference model of the stored contents
  logic              m_v   [SETS][WAYS];
  logic [TAG_W-1:0]  m_tag [SETS][WAYS];
  logic              m_tp  [SETS][WAYS];
  logic [LINE_W-1:0] m_dat [SETS][WAYS];
  logic [NG-1:0]     m_dp  [SETS][WAYS];
  int                m_ptr [SETS];

  function automatic logic [NG-1:0] dpar(logic [LINE_W-1:0] d);
    logic [NG-1:0] p;
    for (int g = 0; g < NG; g++) p[g] = ^d[g*GRAN_W +: GRAN_W];
    return p;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(int t, int s);
    return {TAG_W'(t), INDEX_W'(s)};
  endfunction

  function automatic int way_of(logic [ADDR_W-1:0] a);
    for (int w = 0; w < WAYS; w++)
      if (m_v[a[1:0]][w] && m_tag[a[1:0]][w] == a[ADDR_W-1:INDEX_W]) return w;
    return -1;
  endfunction

  task automatic chk(string rq, bit e_rdy, bit e_rv, logic [LINE_W-1:0] e_rd,
                     bit e_fr, logic [ADDR_W-1:0] e_fa, bit e_ev, logic [1:0] e_es);
    bit bad;
    compared++;
    bad = (req_ready !== e_rdy) || (rsp_valid !== e_rv) || (e_rv && rsp_data !== e_rd) ||
          (fill_req_valid !== e_fr) || (e_fr && fill_req_addr !== e_fa) ||
          (err_valid !== e_ev) || (e_ev && err_src !== e_es);
    if (bad) begin
      mismatched++;
      $display("FAIL %s: got rdy=%0b rv=%0b rd=%h fr=%0b fa=%h ev=%0b es=%b | exp rdy=%0b rv=%0b rd=%h fr=%0b fa=%h ev=%0b es=%b",
               rq, req_ready, rsp_valid, rsp_data, fill_req_valid, fill_req_addr, err_valid, err_src,
               e_rdy, e_rv, e_rd, e_fr, e_fa, e_ev, e_es);
    end
  endtask

  task automatic inject(string rq, int s, int w, bit is_tag, logic [LINE_W-1:0] mask);
    @(negedge clk);
    chk(rq, 1, 0, '0, 0, '0, 0, '0);
    inj_valid = 1; inj_set = INDEX_W'(s); inj_way = w[0]; inj_tag = is_tag; inj_mask = mask;
    @(posedge clk); #1 inj_valid = 0;
    if (is_tag) m_tag[s][w] ^= mask[TAG_W-1:0];
    else        m_dat[s][w] ^= mask;
  endtask

  task automatic fetch(string rq, logic [ADDR_W-1:0] a, int delay, logic [LINE_W-1:0] fd,
                       bit inj_on_fill = 0, logic [LINE_W-1:0] inj_m = '0);
    int s, hw, vic;
    bit t_err, d_err;
    logic [TAG_W-1:0] t;
    s = int'(a[INDEX_W-1:0]); t = a[ADDR_W-1:INDEX_W];
    hw = way_of(a);
    t_err = 0;
    for (int w = 0; w < WAYS; w++) if (m_v[s][w] && (^m_tag[s][w]) != m_tp[s][w]) t_err = 1;
    d_err = (hw >= 0) && (dpar(m_dat[s][hw]) != m_dp[s][hw]);

    @(negedge clk);
    chk(rq, 1, 0, '0, 0, '0, 0, '0);
    req_valid = 1; req_addr = a;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(rq, 0, 0, '0, 0, '0, 0, '0);
    if (hw >= 0 && !t_err && !d_err) begin
      @(negedge clk);
      chk(rq, 1, 1, m_dat[s][hw], 0, '0, 0, '0);
    end else begin
      if (t_err || d_err) for (int w = 0; w < WAYS; w++) m_v[s][w] = 0;
      vic = m_ptr[s];
      for (int w = WAYS - 1; w >= 0; w--) if (!m_v[s][w]) vic = w;
      @(negedge clk);
      chk(rq, 0, 0, '0, 1, a, t_err || d_err, {t_err, d_err});
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk(rq, 0, 0, '0, 0, '0, 0, '0);
      end
      @(negedge clk);
      chk(rq, 0, 0, '0, 0, '0, 0, '0);
      fill_rsp_valid = 1; fill_rsp_data = fd;
      if (inj_on_fill) begin
        inj_valid = 1; inj_set = INDEX_W'(s); inj_way = vic[0]; inj_tag = 0; inj_mask = inj_m;
      end
      @(posedge clk); #1 fill_rsp_valid = 0; inj_valid = 0;
      m_v[s][vic] = 1; m_tag[s][vic] = t; m_tp[s][vic] = ^t;
      m_dat[s][vic] = fd; m_dp[s][vic] = dpar(fd);
      m_ptr[s] = (m_ptr[s] + 1) % WAYS;
      @(negedge clk);
      chk(rq, 1, 1, fd, 0, '0, 0, '0);
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a_a, a_b, a_c, a_d, a_e, a_f, a_g;
    for (int s = 0; s < SETS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = '0; m_tp[s][w] = 0; m_dat[s][w] = '0; m_dp[s][w] = '0;
      end
    end
    a_a = mk(31'h1234567, 0); a_b = mk(31'h7654321, 0); a_c = mk(31'h0ABCDEF, 1);
    a_d = mk(31'h5555AAA, 2); a_e = mk(31'h0000011, 3); a_f = mk(31'h0000022, 3);
    a_g = mk(31'h0000033, 3);

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset idle", 1, 0, '0, 0, '0, 0, '0);

    fetch("R1 R3 first miss", a_a, 0, 40'hA1_1111_1111);
    fetch("R2 hit after fill", a_a, 0, '0);
    fetch("R8 R3 second way fill", a_b, 2, 40'hB2_2222_2222);
    fetch("R2 hit way1", a_b, 0, '0);
    fetch("R3 miss long wait", a_c, 5, 40'hC3_3333_3333);

    // single data flip in low slice of A
    inject("R9 inject data", 0, way_of(a_a), 0, 40'h00_0000_0010);
    fetch("R4 R5 R6 data fault", a_a, 1, 40'hA1_1111_1111);
    fetch("R5 other way invalidated", a_b, 0, 40'hB2_2222_2222);

    // tag flip in the non-matching way
    inject("R9 inject tag", 0, way_of(a_b), 1, 40'h00_4000_0000);
    fetch("R5 R6 tag fault in other way", a_a, 0, 40'hA1_1111_1111);
    fetch("R5 refill after tag fault", a_b, 0, 40'hB2_2222_2222);

    // tag and data faults in one lookup
    inject("R9 inject data upper slice", 0, way_of(a_a), 0, 40'h80_0000_0000);
    inject("R9 inject tag other way", 0, way_of(a_b), 1, 40'h00_0000_0001);
    fetch("R6 both sources", a_a, 0, 40'hA1_1111_1111);
    fetch("R5 refill B", a_b, 0, 40'hB2_2222_2222);

    // even flip in one slice stays hidden; flips in two slices are caught
    inject("R7 inject double flip", 0, way_of(a_a), 0, 40'h00_0000_0003);
    fetch("R7 undetected double flip", a_a, 0, '0);
    inject("R4 inject one per slice", 0, way_of(a_a), 0, 40'h00_0010_0001);
    fetch("R4 per-slice detection", a_a, 0, 40'hA1_1111_1111);

    // refill write and injection on the same edge
    fetch("R9 fill with colliding injection", a_d, 1, 40'hD4_4444_4444, 1, 40'h00_0000_0100);
    fetch("R9 fill wins over injection", a_d, 0, '0);

    // replacement pointer in a full set
    fetch("R8 fill E", a_e, 0, 40'hE5_5555_5555);
    fetch("R8 fill F", a_f, 0, 40'hF6_6666_6666);
    fetch("R8 fill G evicts by pointer", a_g, 0, 40'h17_7777_7777);
    fetch("R8 F kept", a_f, 0, '0);
    fetch("R8 E evicted", a_e, 0, 40'hE5_5555_5555);
    fetch("R8 G kept", a_g, 0, '0);
    fetch("R2 other set untouched", a_c, 0, '0);

    @(negedge clk);
    chk("R1 idle at end", 1, 0, '0, 0, '0, 0, '0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule